// File: doc/BRIEF.md
# Accumulator ALU with Carry, Parity, Zero and Sign Flags

This block is the data-path core of a small 8-bit processor. On each cycle in which an operation is offered, it combines the accumulator with an operand, or transforms one of them, and then registers the result. It also updates a four-bit condition register. There are four operation classes. The two-operand class has eight functions: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. The rotate class has four accumulator rotates, two circular and two through carry. The remaining two classes increment or decrement a general register value.

Each class updates its own subset of the flags. The carry flag held in the condition register feeds the with-carry arithmetic and the through-carry rotates, so a chain of operations can pass a carry from one to the next. The surrounding processor supplies the accumulator and operand values and picks the operation. It writes the registered result back when the result-write strobe is high. The condition register is written only when the flag-write input is high.

Top module: `acc_alu`

## Requirements
- R1: With `op_class` = 00, `op_fn` selects the function as follows: 000 gives A+B, 001 gives A+B+C, 010 gives A−B, 011 gives A−B−C. Here C is the stored carry flag, and the 8-bit result wraps modulo 256.
- R2: With `op_class` = 00, `op_fn` 100 gives A AND B, 101 gives A XOR B and 110 gives A OR B. All three clear carry.
- R3: With `op_class` = 00 and `op_fn` = 111 (compare), `res_we` stays low. The flags are set as for A−B.
- R4: For subtract and subtract-with-borrow, carry is the borrow. It is set exactly when B plus the borrow-in is greater than A, taken as unsigned values. For add and add-with-carry, carry is the carry out of bit 7.
- R5: Every operation in class 00 sets zero, sign and parity from its 8-bit result, and compare uses A−B as that result. Zero means the result is 0, sign is result bit 7, and parity is 1 when the result has an even number of ones. The layout of `flags` is bit 3 sign, bit 2 zero, bit 1 parity, bit 0 carry.
- R6: With `op_class` = 01, `op_fn[1:0]` = 00 rotates A left, and the old bit 7 goes to both bit 0 and carry. The code 01 rotates A right, and the old bit 0 goes to both bit 7 and carry. `op_fn[2]` is ignored.
- R7: With `op_class` = 01, `op_fn[1:0]` = 10 rotates A left through carry: bit 7 goes to carry and the old carry goes to bit 0. The code 11 rotates A right through carry: bit 0 goes to carry and the old carry goes to bit 7.
- R8: A rotate changes only the carry flag. Sign, zero and parity keep their values.
- R9: With `op_class` = 10 the result is B+1, and with 11 it is B−1, both modulo 256. Zero, sign and parity follow the result, and carry keeps its value.
- R10: When `flag_we` is low, `flags` does not change. The result is still produced and written.
- R11: The result, its write strobe and the new flags appear at the first clock edge after `op_valid` is sampled high. `res_we` is low after any cycle in which `op_valid` is low.
- R12: While `rst_n` is low at a clock edge, `res`, `res_we` and `flags` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_class | input | 2 | 00 two-operand, 01 rotate, 10 increment, 11 decrement |
| op_fn | input | 3 | Function within the class |
| acc_in | input | 8 | Accumulator value A |
| opnd | input | 8 | Operand or register value B |
| flag_we | input | 1 | Allow the condition register to be written |
| res | output | 8 | Registered result |
| res_we | output | 1 | Result should be written back |
| flags | output | 4 | Condition register {sign, zero, parity, carry} |

## Verification
Two things can land on the same clock edge: an operation consuming the stored carry, and the preceding operation producing that carry. The bench provokes this by issuing add-with-carry, subtract-with-borrow and through-carry rotates immediately after carry-producing operations, with no idle gap between them. It also interleaves flag-write-disabled operations into such chains. Each result is judged against a bench model that keeps its own copy of the condition register. A design that reads the carry a cycle late, or that lets a disabled write disturb the chain, shows up as a mismatch.

// File: rtl/acc_alu_pkg.sv
// Shared types for the accumulator ALU: operation classes, function codes,
// rotate modes and the packed condition-register layout.
package acc_alu_pkg;

    typedef enum logic [1:0] {
        CLS_TWO = 2'b00,
        CLS_ROT = 2'b01,
        CLS_INC = 2'b10,
        CLS_DEC = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'b000,
        FN_ADC = 3'b001,
        FN_SUB = 3'b010,
        FN_SBB = 3'b011,
        FN_AND = 3'b100,
        FN_XOR = 3'b101,
        FN_OR  = 3'b110,
        FN_CMP = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        ROT_LCIRC = 2'b00,
        ROT_RCIRC = 2'b01,
        ROT_LTHRU = 2'b10,
        ROT_RTHRU = 2'b11
    } rot_mode_e;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } cond_t;

endpackage

// File: rtl/acc_alu_arith.sv
// Two-operand function unit. It computes add/sub (with optional carry or
// borrow in) and the bitwise functions. Compare returns the difference.
// Assumes cin is the stored carry flag; carry out is the borrow for
// subtract-type functions and 0 for the bitwise functions.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         cout
);
    localparam int EW = W + 1;

    logic          use_cin;
    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    logic [EW-1:0] ext_c;
    logic [EW-1:0] sum;
    logic [EW-1:0] dif;

    // Widen the operands by one bit so the top bit carries the carry or borrow
    always_comb begin
        use_cin = (fn == FN_ADC) || (fn == FN_SBB);
        ext_a   = {1'b0, a};
        ext_b   = {1'b0, b};
        ext_c   = {{W{1'b0}}, use_cin & cin};
        sum     = ext_a + ext_b + ext_c;
        dif     = ext_a - ext_b - ext_c;
    end

    // Select the function output and its carry
    always_comb begin
        unique case (fn)
            FN_ADD, FN_ADC: begin
                y    = sum[W-1:0];
                cout = sum[W];
            end
            FN_SUB, FN_SBB, FN_CMP: begin
                y    = dif[W-1:0];
                cout = dif[W];
            end
            FN_AND: begin
                y    = a & b;
                cout = 1'b0;
            end
            FN_XOR: begin
                y    = a ^ b;
                cout = 1'b0;
            end
            default: begin
                y    = a | b;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_rot.sv
// Single-position accumulator rotator. It has two circular modes and two
// modes that rotate through the carry flag. Assumes cin is the stored carry.
module acc_alu_rot
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  rot_mode_e    mode,
    output logic [W-1:0] y,
    output logic         cout
);
    // Pick the bit entering the vacated end and the bit leaving to carry
    always_comb begin
        unique case (mode)
            ROT_LCIRC: begin
                y    = {a[W-2:0], a[W-1]};
                cout = a[W-1];
            end
            ROT_RCIRC: begin
                y    = {a[0], a[W-1:1]};
                cout = a[0];
            end
            ROT_LTHRU: begin
                y    = {a[W-2:0], cin};
                cout = a[W-1];
            end
            default: begin
                y    = {cin, a[W-1:1]};
                cout = a[0];
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_step.sv
// Register increment/decrement by one, modulo 2**W. It has no carry output
// by design: the caller keeps the carry flag unchanged for these operations.
module acc_alu_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] y
);
    // Add or subtract one
    always_comb begin
        y = down ? (val - W'(1)) : (val + W'(1));
    end

endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU top. It decodes the operation class and routes the
// operands to the two-operand unit, the rotator or the step unit. It then
// builds the next condition register and registers the result, the
// write-back strobe and the flags. Assumes acc_in and opnd are stable while
// op_valid is high; the reset is synchronous and active low.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_class,
    input  logic [2:0]        op_fn,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd,
    input  logic              flag_we,
    output logic [DATA_W-1:0] res,
    output logic              res_we,
    output logic [3:0]        flags
);
    localparam int MSB = DATA_W - 1;

    op_class_e         cls;
    alu_fn_e           fn;
    rot_mode_e         rmode;
    cond_t             cond_q;
    cond_t             cond_d;
    logic [DATA_W-1:0] two_y;
    logic              two_c;
    logic [DATA_W-1:0] rot_y;
    logic              rot_c;
    logic [DATA_W-1:0] step_y;
    logic [DATA_W-1:0] nxt_y;
    logic              is_cmp;
    logic [DATA_W-1:0] res_q;
    logic              we_q;

    // Cast the plain input codes into the package types
    always_comb begin
        cls   = op_class_e'(op_class);
        fn    = alu_fn_e'(op_fn);
        rmode = rot_mode_e'(op_fn[1:0]);
    end

    acc_alu_arith #(.W(DATA_W)) u_two (
        .a    (acc_in),
        .b    (opnd),
        .cin  (cond_q.cry),
        .fn   (fn),
        .y    (two_y),
        .cout (two_c)
    );

    acc_alu_rot #(.W(DATA_W)) u_rot (
        .a    (acc_in),
        .cin  (cond_q.cry),
        .mode (rmode),
        .y    (rot_y),
        .cout (rot_c)
    );

    acc_alu_step #(.W(DATA_W)) u_step (
        .val  (opnd),
        .down (cls == CLS_DEC),
        .y    (step_y)
    );

    // Choose the class result and whether it is written back
    always_comb begin
        is_cmp = (cls == CLS_TWO) && (fn == FN_CMP);
        unique case (cls)
            CLS_TWO: nxt_y = two_y;
            CLS_ROT: nxt_y = rot_y;
            default: nxt_y = step_y;
        endcase
    end

    // Build the next condition register from the class-specific update mask
    always_comb begin
        cond_d = cond_q;
        unique case (cls)
            CLS_TWO: begin
                cond_d.cry = two_c;
                cond_d.sgn = nxt_y[MSB];
                cond_d.zro = (nxt_y == '0);
                cond_d.par = ~^nxt_y;
            end
            CLS_ROT: begin
                cond_d.cry = rot_c;
            end
            default: begin
                cond_d.sgn = nxt_y[MSB];
                cond_d.zro = (nxt_y == '0);
                cond_d.par = ~^nxt_y;
            end
        endcase
    end

    // Register the result, the write strobe and the condition register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            we_q   <= 1'b0;
            cond_q <= '0;
        end else begin
            we_q <= op_valid && !is_cmp;
            if (op_valid) begin
                res_q <= nxt_y;
            end
            if (op_valid && flag_we) begin
                cond_q <= cond_d;
            end
        end
    end

    // Drive the outputs from the registers
    always_comb begin
        res    = res_q;
        res_we = we_q;
        flags  = cond_q;
    end

endmodule

// File: rtl/acc_alu_chk.sv
// Temporal checks on the accumulator ALU ports, bound to every instance.
// Flag layout assumed: bit 3 sign, bit 2 zero, bit 1 parity, bit 0 carry.
module acc_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_class,
    input logic [2:0]        op_fn,
    input logic              flag_we,
    input logic [DATA_W-1:0] res,
    input logic              res_we,
    input logic [3:0]        flags
);
    logic two_upd;

    // Two-operand operation with the flag write allowed
    always_comb begin
        two_upd = op_valid && flag_we && (op_class == 2'b00);
    end

    // R11
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_we);

    // R3
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 2'b00 && op_fn == 3'b111) |=> !res_we);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && flag_we) |=> $stable(flags));

    // R8
    rot_keeps_szp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we && op_class == 2'b01) |=> (flags[3:1] == $past(flags[3:1])));

    // R9
    step_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we && op_class[1]) |=> (flags[0] == $past(flags[0])));

    // R2
    logic_clears_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (two_upd && op_fn[2] && op_fn != 3'b111) |=> !flags[0]);

    // R5
    zero_tracks_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (two_upd && op_fn != 3'b111) |=> (flags[2] == (res == '0)));

    // R5
    parity_tracks_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (two_upd && op_fn != 3'b111) |=> (flags[1] == ~^res));

    // R5
    sign_tracks_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (two_upd && op_fn != 3'b111) |=> (flags[3] == res[DATA_W-1]));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_class (op_class),
    .op_fn    (op_fn),
    .flag_we  (flag_we),
    .res      (res),
    .res_we   (res_we),
    .flags    (flags)
);

// File: tb/acc_alu_tb_top.sv
// Scoreboard bench for the accumulator ALU: the driver pushes expected items,
// and the monitor pops and compares them one clock edge after each drive.
module acc_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_class = 2'b00;
    logic [2:0] op_fn = 3'b000;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic       flag_we = 1'b0;
    logic [7:0] res;
    logic       res_we;
    logic [3:0] flags;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] e_res;
        logic       e_we;
        logic [3:0] e_flags;
        bit         chk_res;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    logic [3:0] mflags = 4'h0;

    always #4 clk = ~clk;

    acc_alu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_class (op_class),
        .op_fn    (op_fn),
        .acc_in   (acc_in),
        .opnd     (opnd),
        .flag_we  (flag_we),
        .res      (res),
        .res_we   (res_we),
        .flags    (flags)
    );

    // Reference model: returns {result, write, next flags} from the requirements
    task automatic model(input logic [1:0] cls, input logic [2:0] fn,
                         input logic [7:0] a, input logic [7:0] b,
                         output logic [7:0] r, output logic we, output logic [3:0] nf);
        logic [8:0] t;
        logic       c;
        c  = mflags[0];
        nf = mflags;
        we = 1'b1;
        r  = 8'h00;
        case (cls)
            2'b00: begin
                case (fn)
                    3'd0: t = {1'b0, a} + {1'b0, b};
                    3'd1: t = {1'b0, a} + {1'b0, b} + {8'h00, c};
                    3'd2: t = {1'b0, a} - {1'b0, b};
                    3'd3: t = {1'b0, a} - {1'b0, b} - {8'h00, c};
                    3'd4: t = {1'b0, a & b};
                    3'd5: t = {1'b0, a ^ b};
                    3'd6: t = {1'b0, a | b};
                    default: begin
                        t  = {1'b0, a} - {1'b0, b};
                        we = 1'b0;
                    end
                endcase
                r  = t[7:0];
                nf = {r[7], r == 8'h00, ~^r, t[8]};
            end
            2'b01: begin
                case (fn[1:0])
                    2'd0: begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
                    2'd1: begin r = {a[0], a[7:1]}; nf[0] = a[0]; end
                    2'd2: begin r = {a[6:0], c};    nf[0] = a[7]; end
                    default: begin r = {c, a[7:1]}; nf[0] = a[0]; end
                endcase
            end
            default: begin
                r  = (cls == 2'b10) ? b + 8'd1 : b - 8'd1;
                nf = {r[7], r == 8'h00, ~^r, c};
            end
        endcase
    endtask

    // Driver: apply one operation at the falling edge and push its expectation
    task automatic issue(input logic [1:0] cls, input logic [2:0] fn,
                         input logic [7:0] a, input logic [7:0] b,
                         input logic fwe, input string req);
        exp_t       e;
        logic [7:0] r;
        logic       we;
        logic [3:0] nf;
        @(negedge clk);
        model(cls, fn, a, b, r, we, nf);
        if (fwe) mflags = nf;
        op_valid = 1'b1;
        op_class = cls;
        op_fn    = fn;
        acc_in   = a;
        opnd     = b;
        flag_we  = fwe;
        e.e_res   = r;
        e.e_we    = we;
        e.e_flags = mflags;
        e.chk_res = we;
        e.req     = req;
        sb_q.push_back(e);
    endtask

    // Driver: one cycle with no operation offered
    task automatic idle(input string req);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b0;
        flag_we  = 1'b1;
        acc_in   = 8'hA5;
        opnd     = 8'h5A;
        e.e_res   = 8'h00;
        e.e_we    = 1'b0;
        e.e_flags = mflags;
        e.chk_res = 1'b0;
        e.req     = req;
        sb_q.push_back(e);
    endtask

    // Monitor: after each rising edge, compare the outputs with the oldest item
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (res_we !== e.e_we || flags !== e.e_flags ||
                (e.chk_res && res !== e.e_res)) begin
                n_fail++;
                $display("FAIL %s: res=%02h we=%0b flags=%04b expected res=%02h we=%0b flags=%04b",
                         e.req, res, res_we, flags, e.e_res, e.e_we, e.e_flags);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        n_tests++;
        if (res !== 8'h00 || res_we !== 1'b0 || flags !== 4'h0) begin
            n_fail++;
            $display("FAIL R12: res=%02h we=%0b flags=%04b expected res=00 we=0 flags=0000",
                     res, res_we, flags);
        end
        rst_n = 1'b1;

        // R1 / R5: basic add, wrap to zero with carry
        issue(2'b00, 3'd0, 8'h3C, 8'h42, 1'b1, "R1");
        issue(2'b00, 3'd0, 8'hFF, 8'h01, 1'b1, "R5");
        // R1: add with carry consumes the carry made one edge earlier
        issue(2'b00, 3'd1, 8'h10, 8'h20, 1'b1, "R1");
        // R4: borrow cases
        issue(2'b00, 3'd2, 8'h50, 8'h20, 1'b1, "R4");
        issue(2'b00, 3'd2, 8'h20, 8'h50, 1'b1, "R4");
        issue(2'b00, 3'd3, 8'h05, 8'h05, 1'b1, "R4");
        issue(2'b00, 3'd3, 8'h10, 8'h0F, 1'b1, "R4");
        issue(2'b00, 3'd3, 8'h10, 8'h0F, 1'b1, "R4");
        // R2: logic functions clear a set carry
        issue(2'b00, 3'd2, 8'h00, 8'h01, 1'b1, "R4");
        issue(2'b00, 3'd4, 8'hF0, 8'h3C, 1'b1, "R2");
        issue(2'b00, 3'd5, 8'hAA, 8'hAA, 1'b1, "R2");
        issue(2'b00, 3'd6, 8'h81, 8'h02, 1'b1, "R2");
        // R3: compare writes no result
        issue(2'b00, 3'd7, 8'h20, 8'h50, 1'b1, "R3");
        issue(2'b00, 3'd7, 8'h77, 8'h77, 1'b1, "R3");
        // R6 / R7 / R8: rotates, back to back through carry
        issue(2'b01, 3'd0, 8'h81, 8'h00, 1'b1, "R6");
        issue(2'b01, 3'd5, 8'h01, 8'h00, 1'b1, "R6");
        issue(2'b01, 3'd2, 8'h80, 8'h00, 1'b1, "R7");
        issue(2'b01, 3'd3, 8'h01, 8'h00, 1'b1, "R7");
        issue(2'b01, 3'd2, 8'h40, 8'h00, 1'b1, "R7");
        issue(2'b01, 3'd3, 8'h02, 8'h00, 1'b1, "R8");
        // R9: increment/decrement wraps, carry kept
        issue(2'b00, 3'd2, 8'h00, 8'h01, 1'b1, "R4");
        issue(2'b10, 3'd0, 8'h00, 8'hFF, 1'b1, "R9");
        issue(2'b11, 3'd0, 8'h00, 8'h00, 1'b1, "R9");
        issue(2'b10, 3'd0, 8'h00, 8'h7F, 1'b1, "R9");
        // R10: flag write disabled inside a carry chain
        issue(2'b00, 3'd0, 8'hF0, 8'h20, 1'b1, "R10");
        issue(2'b00, 3'd0, 8'h00, 8'h00, 1'b0, "R10");
        issue(2'b01, 3'd0, 8'h01, 8'h00, 1'b0, "R10");
        issue(2'b00, 3'd1, 8'h01, 8'h01, 1'b1, "R10");
        // R11: idle cycles produce no write and keep flags
        idle("R11");
        idle("R11");
        issue(2'b11, 3'd0, 8'h00, 8'h01, 1'b1, "R11");
        idle("R11");

        // Mixed pseudo-random stream, mostly back to back
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[31:29] == 3'd0) begin
                idle("R11");
            end else begin
                case (rv[1:0])
                    2'b00:   issue(2'b00, rv[4:2], rv[12:5], rv[20:13], rv[21] | rv[22], "R1");
                    2'b01:   issue(2'b01, rv[4:2], rv[12:5], rv[20:13], rv[21] | rv[22], "R7");
                    default: issue(rv[1:0], rv[4:2], rv[12:5], rv[20:13], rv[21] | rv[22], "R9");
                endcase
            end
        end
        idle("R11");

        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule